// File: doc/BRIEF.md
# Pipelined Scaled Eight-Point DCT

This block computes a one-dimensional eight-point DCT-II with a factored fast butterfly network. Eight signed fixed-point samples arrive in parallel on one cycle. Eight coefficients leave in parallel a fixed number of cycles later. A new input vector can be taken on every clock, so the block can sit in a row/column transform loop without stalling. The datapath is almost all adders and subtractors. Only five constant multipliers are needed, and they sit in three separate pipeline stages.

The coefficients are not normalized. Coefficient k equals the unnormalized cosine sum G(k) = sum over n of x[n]·cos((2n+1)kπ/16), multiplied by a fixed per-lane factor: s(0) = 1 and s(k) = 2·cos(kπ/16) for k > 0. A downstream quantizer is expected to fold these factors into its own step sizes. A valid flag travels with each vector so that the consumer knows which output cycles carry results.

Top module: `dct8_aan_pipe`

## Requirements
- R1: The block accepts an input vector on every cycle that `in_valid` is high, including runs of back-to-back cycles. Consecutive accepted vectors leave on consecutive cycles.
- R2: An accepted vector's results are presented together with `out_valid` high exactly 8 clock cycles after the cycle in which it was accepted. `out_valid` is high in no other cycle.
- R3: Samples and coefficients are 22-bit two's complement with 8 fractional bits. Lane k occupies bits [22k+21:22k] of `in_vec` and `out_vec`. Fractional input bits are carried through: eight inputs of one LSB give lane 0 equal to 8 LSB.
- R4: For inputs in the pixel range (|x| ≤ 255·256 LSB), lane k differs from s(k)·G(k) by at most 16 + (Σ|x|)/64 LSB. Here s(0) = 1 and s(k) = 2·cos(kπ/16).
- R5: Lane 0 equals the exact sum of the eight inputs. Lane 4 equals the exact alternating sum x0−x1−x2+x3+x4−x5−x6+x7. Neither lane passes through a multiplier.
- R6: A synchronous active-high `rst` clears `out_valid` on the next edge. Vectors accepted before or during reset never produce an output.
- R7: An antisymmetric input (x[n] = −x[7−n]) gives exactly zero on lanes 0, 2, 4 and 6.
- R8: A symmetric input (x[n] = x[7−n]) gives exactly zero on lanes 1, 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | The vector on `in_vec` is accepted this cycle |
| in_vec | input | 176 | Eight 22-bit signed Q8 samples; lane k at bits [22k+21:22k] |
| out_valid | output | 1 | `out_vec` carries the result of a vector accepted 8 cycles earlier |
| out_vec | output | 176 | Eight 22-bit signed Q8 scaled coefficients; lane k at bits [22k+21:22k] |

## Verification
The hardest behaviour to reach is an error in the odd lanes that only shows when several constant multipliers feed one another. Such an error stays hidden on smooth or constant inputs. The stimulus therefore walks a unit impulse through every position at both polarities and adds a long run of pseudo-random signed vectors, so that each rotation path is driven alone and in combination. A mid-stream reset with vectors in flight, and a stream broken by single-cycle bubbles, show that results are neither lost, duplicated nor shifted in time.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int LANES   = 8;
  localparam int LATENCY = 8;

  // Round a real rotation constant to a signed fixed-point integer
  function automatic int fix_const(input real value, input int frac_bits);
    return $rtoi(value * (2.0 ** frac_bits) + 0.5);
  endfunction

endpackage

// File: rtl/dct8_cmult.sv
// Constant multiplier: y = round(a * COEF / 2^CF), rounding half up
module dct8_cmult #(
  parameter int IW   = 26,
  parameter int CF   = 8,
  parameter int CW   = 11,
  parameter int COEF = 181
) (
  input  logic signed [IW-1:0] a,
  output logic signed [IW-1:0] y
);
  localparam int PW = IW + CW;
  localparam logic signed [CW-1:0] K = CW'(COEF);
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (CF - 1));

  logic signed [PW-1:0] a_ext, k_ext, prod, rnd;

  assign a_ext = {{CW{a[IW-1]}}, a};
  assign k_ext = {{IW{K[CW-1]}}, K};
  assign prod  = a_ext * k_ext;
  assign rnd   = prod + HALF;
  assign y     = IW'(rnd >>> CF);

endmodule

// File: rtl/dct8_valid_pipe.sv
// Valid flag shift chain that runs alongside the datapath stages
module dct8_valid_pipe #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic out_valid
);
  logic [LAT-1:0] vq;

  always_ff @(posedge clk) begin
    if (rst) vq[0] <= 1'b0;
    else     vq[0] <= in_valid;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vq[s] <= 1'b0;
      else     vq[s] <= vq[s-1];
    end
  end

  assign out_valid = vq[LAT-1];

  // Cycles since reset, saturating; it only gates the latency check
  localparam int CNTW = $clog2(LAT + 1);
  logic [CNTW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                        since_rst <= '0;
    else if (since_rst != CNTW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  // R2: once the chain has filled after reset, out_valid mirrors in_valid LAT cycles back
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CNTW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R6: reset empties the chain on the next edge
  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/dct8_aan_pipe.sv
// Eight-stage factored DCT-II; outputs keep per-lane scale s(k)
module dct8_aan_pipe
  import dct8_pkg::*;
#(
  parameter int W     = 22,
  parameter int GUARD = 4,
  parameter int CFRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [LANES*W-1:0]   in_vec,
  output logic                 out_valid,
  output logic [LANES*W-1:0]   out_vec
);
  localparam int IW = W + GUARD;
  localparam int CW = CFRAC + 3;
  localparam int K_C4 = fix_const(0.70710678, CFRAC);
  localparam int K_C6 = fix_const(0.38268343, CFRAC);
  localparam int K_R2 = fix_const(0.54119610, CFRAC);
  localparam int K_R6 = fix_const(1.30656296, CFRAC);

  typedef logic signed [IW-1:0] word_t;

  word_t x [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign x[i] = {{GUARD{in_vec[i*W+W-1]}}, in_vec[i*W +: W]};
  end

  // Stage 1: outer butterflies. a1[0..3] sums, a1[4..7] differences
  word_t a1 [LANES];
  for (genvar i = 0; i < LANES/2; i++) begin : g_bfly
    always_ff @(posedge clk) begin
      a1[i]         <= x[i] + x[LANES-1-i];
      a1[LANES-1-i] <= x[i] - x[LANES-1-i];
    end
  end

  // Stage 2: even butterflies and odd pair sums
  word_t e10, e11, e12, e13, o10, o11, o12, t7_2;
  always_ff @(posedge clk) begin
    e10  <= a1[0] + a1[3];
    e13  <= a1[0] - a1[3];
    e11  <= a1[1] + a1[2];
    e12  <= a1[1] - a1[2];
    o10  <= a1[4] + a1[5];
    o11  <= a1[5] + a1[6];
    o12  <= a1[6] + a1[7];
    t7_2 <= a1[7];
  end

  // Stage 3: lanes 0/4 complete, first multiply
  word_t y0_3, y4_3, sm_3, k13_3, dd_3, k10_3, k12_3, m3_3, t7_3, m3_w;
  dct8_cmult #(.IW(IW), .CF(CFRAC), .CW(CW), .COEF(K_C4)) u_mul_c4a (.a(o11), .y(m3_w));
  always_ff @(posedge clk) begin
    y0_3  <= e10 + e11;
    y4_3  <= e10 - e11;
    sm_3  <= e12 + e13;
    k13_3 <= e13;
    dd_3  <= o10 - o12;
    k10_3 <= o10;
    k12_3 <= o12;
    m3_3  <= m3_w;
    t7_3  <= t7_2;
  end

  // Stage 4: second multiply pair
  word_t y0_4, y4_4, k13_4, m1_4, m5_4, k10_4, k12_4, m3_4, t7_4, m1_w, m5_w;
  dct8_cmult #(.IW(IW), .CF(CFRAC), .CW(CW), .COEF(K_C4)) u_mul_c4b (.a(sm_3), .y(m1_w));
  dct8_cmult #(.IW(IW), .CF(CFRAC), .CW(CW), .COEF(K_C6)) u_mul_c6  (.a(dd_3), .y(m5_w));
  always_ff @(posedge clk) begin
    y0_4  <= y0_3;
    y4_4  <= y4_3;
    k13_4 <= k13_3;
    m1_4  <= m1_w;
    m5_4  <= m5_w;
    k10_4 <= k10_3;
    k12_4 <= k12_3;
    m3_4  <= m3_3;
    t7_4  <= t7_3;
  end

  // Stage 5: third multiply pair
  word_t y0_5, y4_5, k13_5, m1_5, m5_5, m3_5, t7_5, p2_5, p4_5, p2_w, p4_w;
  dct8_cmult #(.IW(IW), .CF(CFRAC), .CW(CW), .COEF(K_R2)) u_mul_r2 (.a(k10_4), .y(p2_w));
  dct8_cmult #(.IW(IW), .CF(CFRAC), .CW(CW), .COEF(K_R6)) u_mul_r6 (.a(k12_4), .y(p4_w));
  always_ff @(posedge clk) begin
    y0_5  <= y0_4;
    y4_5  <= y4_4;
    k13_5 <= k13_4;
    m1_5  <= m1_4;
    m5_5  <= m5_4;
    m3_5  <= m3_4;
    t7_5  <= t7_4;
    p2_5  <= p2_w;
    p4_5  <= p4_w;
  end

  // Stage 6: lanes 2/6 complete, odd partial sums
  word_t y0_6, y4_6, y2_6, y6_6, z2_6, z4_6, z11_6, z13_6;
  always_ff @(posedge clk) begin
    y0_6  <= y0_5;
    y4_6  <= y4_5;
    y2_6  <= k13_5 + m1_5;
    y6_6  <= k13_5 - m1_5;
    z2_6  <= p2_5 + m5_5;
    z4_6  <= p4_5 + m5_5;
    z11_6 <= t7_5 + m3_5;
    z13_6 <= t7_5 - m3_5;
  end

  // Stage 7: odd lanes complete
  word_t y7 [LANES];
  always_ff @(posedge clk) begin
    y7[0] <= y0_6;
    y7[4] <= y4_6;
    y7[2] <= y2_6;
    y7[6] <= y6_6;
    y7[5] <= z13_6 + z2_6;
    y7[3] <= z13_6 - z2_6;
    y7[1] <= z11_6 + z4_6;
    y7[7] <= z11_6 - z4_6;
  end

  // Stage 8: registered outputs, trimmed to the port format
  for (genvar i = 0; i < LANES; i++) begin : g_out
    always_ff @(posedge clk) out_vec[i*W +: W] <= W'(y7[i]);
  end

  dct8_valid_pipe #(.LAT(LATENCY)) u_valid (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid)
  );

  // Properties relate stage-1 registers to the output port LATENCY-1 cycles later
  logic even_in_zero, odd_in_zero;
  word_t s1_sum;
  assign even_in_zero = (a1[0] == '0) && (a1[1] == '0) && (a1[2] == '0) && (a1[3] == '0);
  assign odd_in_zero  = (a1[4] == '0) && (a1[5] == '0) && (a1[6] == '0) && (a1[7] == '0);
  assign s1_sum       = a1[0] + a1[1] + a1[2] + a1[3];

  // R5: lane 0 is the exact sum of the accepted samples
  p_dc_sum_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_vec[0 +: W] == W'($past(s1_sum, LATENCY-1))));

  // R7: antisymmetric input leaves every even lane at zero
  p_even_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(even_in_zero, LATENCY-1)) |->
      (out_vec[0*W +: W] == '0 && out_vec[2*W +: W] == '0 &&
       out_vec[4*W +: W] == '0 && out_vec[6*W +: W] == '0));

  // R8: symmetric input leaves every odd lane at zero
  p_odd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(odd_in_zero, LATENCY-1)) |->
      (out_vec[1*W +: W] == '0 && out_vec[3*W +: W] == '0 &&
       out_vec[5*W +: W] == '0 && out_vec[7*W +: W] == '0));

endmodule

// File: tb/dct8_aan_pipe_tb.sv
module dct8_aan_pipe_tb_top;
  localparam int  CLK_PERIOD = 10;
  localparam int  W  = 22;
  localparam int  N  = 8;
  localparam int  LAT = 8;
  localparam int  WDOG = 20000;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N*W-1:0] in_vec = '0;
  logic out_valid;
  logic [N*W-1:0] out_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct8_aan_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  typedef struct { logic [N*W-1:0] v; int t; } item_t;
  item_t sbq [$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_in_t = -10;
  int last_out_cyc = -10;
  bit done = 1'b0;
  int seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lane(input logic [N*W-1:0] v, input int k);
    logic signed [W-1:0] s;
    s = v[k*W +: W];
    return int'(s);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int x [N]);
    logic [N*W-1:0] v;
    item_t it;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(x[i]);
    @(negedge clk);
    in_valid = 1'b1;
    in_vec   = v;
    it.v = v;
    it.t = cyc;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_vec   = '0;
    end
  endtask

  function automatic int rnd_pix();
    seed = seed * 1103515245 + 12345;
    return int'((seed >>> 10) & 32'hFFFF) - 32768;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Compare one result vector against the reference computed from its inputs
  task automatic score(input item_t it);
    int  x [N];
    real g, s, e, tol, sabs;
    int  act, sum, alt;
    bit  sym, asym;
    for (int i = 0; i < N; i++) x[i] = lane(it.v, i);
    sabs = 0.0; sum = 0; sym = 1'b1; asym = 1'b1;
    for (int i = 0; i < N; i++) begin
      sabs += (x[i] < 0) ? -real'(x[i]) : real'(x[i]);
      sum  += x[i];
      if (x[i] != x[N-1-i])  sym  = 1'b0;
      if (x[i] != -x[N-1-i]) asym = 1'b0;
    end
    alt = x[0] - x[1] - x[2] + x[3] + x[4] - x[5] - x[6] + x[7];
    tol = 16.0 + sabs / 64.0;
    check(cyc - it.t == LAT, "R2", "latency", cyc - it.t, LAT);
    if (it.t == last_in_t + 1)
      check(cyc == last_out_cyc + 1, "R1", "back-to-back output spacing", cyc - last_out_cyc, 1);
    last_in_t = it.t;
    last_out_cyc = cyc;
    for (int k = 0; k < N; k++) begin
      g = 0.0;
      for (int n = 0; n < N; n++) g += real'(x[n]) * $cos(real'((2*n+1)*k) * PI / 16.0);
      s = (k == 0) ? 1.0 : 2.0 * $cos(real'(k) * PI / 16.0);
      e = g * s;
      act = lane(out_vec, k);
      check((real'(act) - e <= tol) && (e - real'(act) <= tol), "R4",
            $sformatf("lane %0d accuracy", k), act, longint'($rtoi(e)));
    end
    check(lane(out_vec, 0) == sum, "R5", "lane 0 exact sum", lane(out_vec, 0), sum);
    check(lane(out_vec, 4) == alt, "R5", "lane 4 exact alternating sum", lane(out_vec, 4), alt);
    if (asym)
      for (int k = 0; k < N; k += 2)
        check(lane(out_vec, k) == 0, "R7", $sformatf("antisymmetric lane %0d", k), lane(out_vec, k), 0);
    if (sym)
      for (int k = 1; k < N; k += 2)
        check(lane(out_vec, k) == 0, "R8", $sformatf("symmetric lane %0d", k), lane(out_vec, k), 0);
  endtask

  // Monitor: samples a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      if (cyc > WDOG) begin
        check(1'b0, "R2", "watchdog expired", cyc, WDOG);
        finish_run();
      end
      if (!rst) begin
        if (sbq.size() != 0 && (cyc - sbq[0].t) > LAT) begin
          check(1'b0, "R2", "missing output", cyc - sbq[0].t, LAT);
          void'(sbq.pop_front());
        end
        if (out_valid) begin
          if (sbq.size() == 0) check(1'b0, "R2", "unexpected out_valid", 1, 0);
          else score(sbq.pop_front());
        end
      end
    end
  end

  initial begin
    int v [N];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    // R6: reset state
    check(out_valid == 1'b0, "R6", "out_valid after reset", out_valid, 0);

    // R3: one-LSB fractional inputs survive
    for (int i = 0; i < N; i++) v[i] = 1;
    send(v);
    for (int i = 0; i < N; i++) v[i] = -1;
    send(v);
    idle(1);
    repeat (LAT) @(negedge clk);
    check(sbq.size() == 0, "R3", "fractional vectors drained", sbq.size(), 0);

    // R1/R4: impulses at every position, both polarities, back to back
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) v[i] = (i == p) ? (255 << 8) : 0;
      send(v);
    end
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) v[i] = (i == p) ? -(128 << 8) : 0;
      send(v);
    end

    // R5: constant vectors, including a fractional part
    for (int i = 0; i < N; i++) v[i] = 0;            send(v);
    for (int i = 0; i < N; i++) v[i] = 255 << 8;     send(v);
    for (int i = 0; i < N; i++) v[i] = -(128 << 8);  send(v);
    for (int i = 0; i < N; i++) v[i] = (37 << 8) + 171; send(v);

    // R4: ramp
    for (int i = 0; i < N; i++) v[i] = (i * 32) << 8;
    send(v);

    // R7/R8: symmetric and antisymmetric patterns
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N/2; i++) begin
        v[i] = rnd_pix();
        v[N-1-i] = v[i];
      end
      send(v);
      for (int i = 0; i < N/2; i++) begin
        v[i] = rnd_pix();
        v[N-1-i] = -v[i];
      end
      send(v);
    end

    // R2/R4: random vectors with bubbles
    for (int r = 0; r < 200; r++) begin
      for (int i = 0; i < N; i++) v[i] = rnd_pix();
      send(v);
      if (r % 3 == 2) idle(1);
      if (r % 17 == 5) idle(2);
    end
    idle(1);
    repeat (LAT + 2) @(negedge clk);
    check(sbq.size() == 0, "R2", "all results delivered", sbq.size(), 0);

    // R6: reset with vectors in flight drops them
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) v[i] = rnd_pix();
      send(v);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sbq.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < LAT + 4; c++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(out_valid == 1'b0, "R6", "no output after mid-stream reset", out_valid, 0);
    end

    // Stream resumes normally after reset
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) v[i] = rnd_pix();
      send(v);
    end
    idle(1);
    repeat (LAT + 2) @(negedge clk);
    check(sbq.size() == 0, "R2", "post-reset results delivered", sbq.size(), 0);
    finish_run();
  end

endmodule